// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable ratio N in the range 240 to 131071. A dual-modulus prescaler counts either 16 or 17 input clocks per cycle. A main counter sets how many prescaler cycles make up one output period. A swallow counter sets how many of those cycles use the longer modulus. The overall ratio is 16·M + A, and the block emits a single-clock pulse once per period.

A new ratio is written through a 17-bit word with a one-cycle load strobe. The word is held pending and takes effect only at the boundary of the current output period, so a period is never cut short or stretched while a ratio changes. A ratio the structure cannot produce is replaced by the minimum ratio, and a flag reports the replacement. A second output toggles on every pulse and gives a divided-by-2 copy of the output for observation.

Top module: `pswallow_div`

## Requirements
- R1: `ratio_i[16:4]` is the main count M and `ratio_i[3:0]` is the swallow count A. For a valid ratio, consecutive rising `pulse_o` events are exactly 16·M + A input clocks apart.
- R2: In each output period, the first A prescaler cycles last 17 clocks and the remaining M − A cycles last 16 clocks.
- R3: `pulse_o` is high for exactly one clock per output period.
- R4: A ratio captured by `load_i` does not change the period already in progress. It governs every period that starts after that period's end.
- R5: When `load_i` is asserted more than once within a period, only the last ratio written is adopted at the boundary.
- R6: A ratio below 240, which includes every ratio with M < A, yields periods of 240 clocks with `invalid_o` = 1. A valid ratio yields `invalid_o` = 0.
- R7: `invalid_o` changes only at a period boundary, in the same clock in which `pulse_o` rises.
- R8: `half_o` inverts on every `pulse_o` and changes at no other time.
- R9: While `rst_ni` is low, `pulse_o`, `half_o` and `invalid_o` are 0. After reset the divider runs at ratio 240.
- R10: The end ratios 240 (M = 15, A = 0) and 131071 (M = 8191, A = 15) are accepted unchanged, along with the case M = A (255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 17 | Requested ratio: M in the upper 13 bits, A in the lower 4 bits |
| load_i | input | 1 | One-cycle strobe that captures `ratio_i` as pending |
| pulse_o | output | 1 | One-clock pulse per output period |
| half_o | output | 1 | Output divided by two (toggles per pulse) |
| invalid_o | output | 1 | The active ratio was replaced by the minimum |

## Verification
The bench measures the spacing between pulses for ratios chosen to separate the two moduli:
- A ratio with A = 0 (256) and one with A = M (255) expose any error in how many prescaler cycles are stretched to 17 clocks.
- Mixed ratios such as 1000 and 4097 catch a swapped or shifted field.
- Each load is placed mid-period, so the pulse spacing shows whether the running period stayed at the old ratio and the next one took the new ratio.
- A double load within one period checks which write is adopted.
- Ratios of 239, 0 and 89 (where M < A) must produce a 240-clock period with the flag set.
- The largest ratio confirms that the full counter width is used.

// File: rtl/psd_pkg.sv
package psd_pkg;
  parameter int M_W   = 13;
  parameter int A_W   = 4;
  parameter int N_MIN = 240;
  localparam int N_W  = M_W + A_W;
  localparam logic [N_W-1:0] N_RST = N_W'(N_MIN);

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
  } ratio_t;

  function automatic logic ratio_bad(input logic [N_W-1:0] n);
    ratio_t r;
    r = ratio_t'(n);
    return (n < N_RST) || (int'(r.m) < int'(r.a));
  endfunction

  function automatic ratio_t ratio_fix(input logic [N_W-1:0] n);
    return ratio_bad(n) ? ratio_t'(N_RST) : ratio_t'(n);
  endfunction
endpackage

// File: rtl/psd_ratio_sync.sv
module psd_ratio_sync
  import psd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] ratio_i,
  input  logic           load_i,
  input  logic           wrap_i,
  output ratio_t         nxt_o,
  output logic           invalid_o
);
  logic [N_W-1:0] pend_q;
  logic           pend_v_q;
  ratio_t         act_q;
  logic           inv_q;
  logic           adopt;

  assign adopt = wrap_i && pend_v_q;
  // reload value seen by the counters at the boundary edge
  assign nxt_o     = adopt ? ratio_fix(pend_q) : act_q;
  assign invalid_o = inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_q    <= ratio_t'(N_RST);
      inv_q    <= 1'b0;
    end else begin
      if (load_i) pend_q <= ratio_i;
      if (load_i)      pend_v_q <= 1'b1;
      else if (wrap_i) pend_v_q <= 1'b0;
      if (adopt) begin
        act_q <= ratio_fix(pend_q);
        inv_q <= ratio_bad(pend_q);
      end
    end
  end

  a_r4_adopt_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wrap_i) |-> $stable(act_q));
  a_r7_flag_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wrap_i) |-> $stable(inv_q));
  a_r6_active_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({act_q.m, act_q.a} >= N_RST) && (int'(act_q.m) >= int'(act_q.a)));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel17_i,
  output logic end_o
);
  localparam logic [A_W:0] LAST16 = (A_W+1)'((2**A_W) - 1);
  localparam logic [A_W:0] LAST17 = (A_W+1)'(2**A_W);

  logic [A_W:0] cnt_q;

  assign end_o = (cnt_q == (sel17_i ? LAST17 : LAST16));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (end_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // the extra count is reached only in a stretched cycle
  a_r2_long_only_when_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST17) |-> sel17_i);
  a_r2_modulus_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(sel17_i));
endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl
  import psd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   end_i,
  input  ratio_t nxt_i,
  output logic   sel17_o,
  output logic   wrap_o
);
  ratio_t rst_r;
  logic [M_W-1:0] m_q;
  logic [A_W-1:0] a_q;

  assign rst_r   = ratio_t'(N_RST);
  assign sel17_o = (a_q != '0);
  assign wrap_o  = end_i && (m_q == M_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= rst_r.m;
      a_q <= rst_r.a;
    end else if (wrap_o) begin
      m_q <= nxt_i.m;
      a_q <= nxt_i.a;
    end else if (end_i) begin
      m_q <= m_q - 1'b1;
      if (a_q != '0) a_q <= a_q - 1'b1;
    end
  end

  a_r2_swallow_within_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(a_q) <= int'(m_q));
  a_r1_main_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_q != '0);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import psd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] ratio_i,
  input  logic           load_i,
  output logic           pulse_o,
  output logic           half_o,
  output logic           invalid_o
);
  ratio_t nxt;
  logic   sel17, pre_end, wrap;
  logic   pulse_q, half_q;

  psd_ratio_sync i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i), .load_i(load_i),
    .wrap_i(wrap), .nxt_o(nxt), .invalid_o(invalid_o)
  );

  psd_prescaler i_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel17_i(sel17), .end_o(pre_end)
  );

  psd_swallow_ctl i_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .end_i(pre_end), .nxt_i(nxt),
    .sel17_o(sel17), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      pulse_q <= wrap;
      half_q  <= half_q ^ wrap;
    end
  end

  assign pulse_o = pulse_q;
  assign half_o  = half_q;

  a_r3_single_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  a_r8_half_tracks_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(half_o) |-> pulse_o);
  a_r7_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(invalid_o) |-> pulse_o);
endmodule

// File: tb/test_pswallow_div.sv
module test_pswallow_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] ratio = '0;
  logic        load = 1'b0;
  logic        pulse, half, inv;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_pulse = 0;
  bit have_last = 0;
  bit last_half = 0;
  bit prev_pulse = 0;
  bit done = 0;

  int    q_n[$];
  bit    q_inv[$];
  string q_tag[$];

  int cur_n = 240;

  always #4 clk = ~clk;

  pswallow_div i_pswallow_div (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .load_i(load),
    .pulse_o(pulse), .half_o(half), .invalid_o(inv)
  );

  function automatic int eff_ratio(input int n);
    if (n < 240 || (n >> 4) < (n & 15)) return 240;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected period per pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (pulse && prev_pulse) chk(0, "R3 pulse wider than one clock", 1, 0);
      if (pulse) begin
        if (have_last) begin
          chk(half != last_half, "R8 half_o toggle", int'(half), int'(!last_half));
          if (q_n.size() > 0) begin
            int    en;
            bit    ei;
            string et;
            en = q_n.pop_front();
            ei = q_inv.pop_front();
            et = q_tag.pop_front();
            chk(cyc - last_pulse == en, et, cyc - last_pulse, en);
            chk(inv == ei, {et, " R6 flag"}, int'(inv), int'(ei));
          end
        end
        last_pulse = cyc;
        last_half  = half;
        have_last  = 1;
      end else if (have_last && half != last_half) begin
        chk(0, "R8 half_o moved without pulse", int'(half), int'(last_half));
      end
      prev_pulse = pulse;
    end
  end

  // driver: loads a ratio mid-period and queues the two periods that follow
  task automatic step(input int n, input int n2, input bit twice, input string tag);
    int f;
    bit fi;
    wait (q_n.size() == 0);
    @(negedge clk);
    ratio = 17'(n);
    load  = 1'b1;
    @(negedge clk);
    if (twice) begin
      ratio = 17'(n2);
      @(negedge clk);
    end
    load = 1'b0;
    f  = eff_ratio(twice ? n2 : n);
    fi = (f != (twice ? n2 : n));
    q_n.push_back(cur_n); q_inv.push_back(fi); q_tag.push_back({tag, " R4 old period kept"});
    q_n.push_back(f);     q_inv.push_back(fi); q_tag.push_back(tag);
    cur_n = f;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pulse == 0, "R9 reset pulse_o", int'(pulse), 0);
    chk(half == 0, "R9 reset half_o", int'(half), 0);
    chk(inv == 0, "R9 reset invalid_o", int'(inv), 0);
    rst_n = 1'b1;
    // sync to the first pulse; default period is 240 (R9)
    do @(negedge clk); while (!pulse);
    step(1000, 0, 0, "R1 ratio 1000 M62 A8");
    step(255, 0, 0, "R10 ratio 255 M=A");
    step(256, 0, 0, "R2 ratio 256 A0");
    step(239, 0, 0, "R6 ratio 239 clamp");
    step(0, 0, 0, "R6 ratio 0 clamp");
    step(89, 0, 0, "R6 ratio 89 M<A clamp");
    step(4097, 0, 0, "R1 ratio 4097");
    step(300, 777, 1, "R5 last load wins 777");
    step(240, 0, 0, "R10 ratio 240 minimum");
    step(131071, 0, 0, "R10 ratio 131071 maximum");
    wait (q_n.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", q_n.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule